// File: doc/BRIEF.md
# Master Clock Ratio Mode Detector

This block works out how a converter is being clocked. It counts rising master-clock edges between successive rising edges of the frame clock (word select). From that count it names the operating speed band and the exact master-to-frame ratio. It then provides the oversampling factor for that band, a lock flag and a reset request. The whole block runs on a free-running reference clock, which must be at least twice as fast as the master clock. Both clock inputs are treated as data: each is resynchronised, and only its rising edges are used.

The ratio is recognised within a window of plus or minus a tolerance around each of seven nominal values. Lock is declared only after two consecutive measurements agree. The reset request is high whenever the block is not locked. A reference-clock watchdog notices when the master clock stops, drops lock at once, and clears the frame measurement. While the block is locked, a one-cycle divide-enable pulse marks every (ratio / oversampling factor) master-clock edges. The pulse count restarts at each frame, so each frame carries exactly one oversampling factor's worth of pulses.

The control state machine has four states. In HUNT there is no candidate ratio. In CONFIRM one legal measurement is held. In LOCKED two consecutive measurements matched. In LOST the master clock has stopped. The transitions are:

- hunt_to_confirm: a legal measurement arrives.
- confirm_to_locked: the same legal ratio is measured again.
- confirm_retarget: a different legal ratio is measured, and the candidate is replaced.
- confirm_to_hunt or locked_to_hunt: an illegal or overrange measurement arrives.
- locked_to_confirm: a different legal ratio is measured.
- any_to_lost: the watchdog expires.
- lost_to_hunt: a master-clock edge is seen again.

Top module: `mrd_ratio_detector`

## Requirements
- R1: A count within 2 of 512, 768 or 1152 gives speed_mode 1 (normal), ratio_code 5, 6 or 7 respectively, and osr_factor 128 once locked.
- R2: A count within 2 of 256 or 384 gives speed_mode 2 (double), ratio_code 3 or 4, and osr_factor 64 once locked.
- R3: A count within 2 of 128 or 192 gives speed_mode 3 (quad), ratio_code 1 or 2, and osr_factor 32 once locked.
- R4: The tolerance is inclusive at 2 counts: a frame of 130 edges locks as ratio_code 1, while a frame of 125 edges is rejected.
- R5: Lock is asserted only after two consecutive equal legal measurements. The first frame-clock rise after reset or after clock loss only starts a count, so lock follows the third frame-clock rise of a new stable ratio.
- R6: While unlocked, speed_mode, ratio_code and osr_factor read 0 and reset_req reads 1. While locked, reset_req reads 0.
- R7: While locked, a measurement of a different legal ratio clears lock in the cycle after that measurement, and the block relocks on the new ratio after one more matching frame.
- R8: While locked, div_en pulses once every 4, 6 or 9 master-clock edges (the ratio divided by the oversampling factor), which gives osr_factor pulses per frame. A pulse is only ever issued when lock was held in the previous cycle.
- R9: If no master-clock edge is seen for loss_window reference cycles, lock drops and reset_req rises within a few cycles of that window. The frame measurement restarts, and the block relocks once clocks return.
- R10: If the frame clock stops while the master clock runs, lock is held until the edge count since the last frame-clock rise passes 2047. The count then ends as an overrange measurement that clears lock.
- R11: A count that is not within tolerance of any of the seven ratios, such as 640, leaves the block unlocked with reset_req high and no div_en pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Free-running reference clock; all state is on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| mclk | input | 1 | Master clock, sampled as data |
| frame_clk | input | 1 | Frame clock (word select), sampled as data |
| loss_window | input | 16 | Reference cycles without a master-clock edge before loss is declared (must be non-zero) |
| locked | output | 1 | A ratio has been confirmed by two matching measurements |
| reset_req | output | 1 | Reset request to downstream logic; high whenever not locked |
| speed_mode | output | 2 | 0 none, 1 normal, 2 double, 3 quad |
| ratio_code | output | 3 | 0 none, 1..7 for ratios 128, 192, 256, 384, 512, 768, 1152 |
| osr_factor | output | 8 | Oversampling factor 128, 64 or 32; 0 when unlocked |
| div_en | output | 1 | One-cycle pulse every ratio/osr master-clock edges while locked |

## Verification
Two things can land in the same reference cycle: a frame measurement that breaks lock, and a divide-enable pulse from the free-running divider. The bench provokes this by changing the ratio in the middle of a locked stream and by feeding an illegal ratio. It samples the lock flag just before and just after the frame boundary that carries the breaking measurement. It also counts the divide pulses over whole unlocked frames, where the count must be zero. A second overlap, a clock stop that arrives while a frame count is still open, is judged by timing the reset request against the programmed loss window. Recovery is then checked by relocking cleanly on a new ratio.

// File: rtl/mrd_pkg.sv
package mrd_pkg;

    typedef enum logic [1:0] {
        SPD_NONE   = 2'd0,
        SPD_NORMAL = 2'd1,
        SPD_DOUBLE = 2'd2,
        SPD_QUAD   = 2'd3
    } speed_e;

    typedef enum logic [2:0] {
        RC_NONE  = 3'd0,
        RC_X128  = 3'd1,
        RC_X192  = 3'd2,
        RC_X256  = 3'd3,
        RC_X384  = 3'd4,
        RC_X512  = 3'd5,
        RC_X768  = 3'd6,
        RC_X1152 = 3'd7
    } ratio_e;

    localparam int unsigned N_RATIOS = 7;

    function automatic int unsigned nominal_of(ratio_e r);
        int unsigned n;
        case (r)
            RC_X128:  n = 128;
            RC_X192:  n = 192;
            RC_X256:  n = 256;
            RC_X384:  n = 384;
            RC_X512:  n = 512;
            RC_X768:  n = 768;
            RC_X1152: n = 1152;
            default:  n = 0;
        endcase
        return n;
    endfunction

    function automatic speed_e speed_of(ratio_e r);
        speed_e s;
        case (r)
            RC_X128, RC_X192:            s = SPD_QUAD;
            RC_X256, RC_X384:            s = SPD_DOUBLE;
            RC_X512, RC_X768, RC_X1152:  s = SPD_NORMAL;
            default:                     s = SPD_NONE;
        endcase
        return s;
    endfunction

    function automatic logic [7:0] osr_of(speed_e s);
        logic [7:0] f;
        case (s)
            SPD_NORMAL: f = 8'd128;
            SPD_DOUBLE: f = 8'd64;
            SPD_QUAD:   f = 8'd32;
            default:    f = 8'd0;
        endcase
        return f;
    endfunction

    // master-clock edges per oversampled tick = ratio / osr
    function automatic logic [3:0] step_of(ratio_e r);
        logic [3:0] d;
        case (r)
            RC_X128, RC_X256, RC_X512: d = 4'd4;
            RC_X192, RC_X384, RC_X768: d = 4'd6;
            RC_X1152:                  d = 4'd9;
            default:                   d = 4'd0;
        endcase
        return d;
    endfunction

    function automatic ratio_e classify(int unsigned cnt, int unsigned tol);
        ratio_e r;
        r = RC_NONE;
        for (int k = 1; k <= int'(N_RATIOS); k++) begin
            if ((cnt + tol >= nominal_of(ratio_e'(3'(k)))) &&
                (cnt <= nominal_of(ratio_e'(3'(k))) + tol)) begin
                r = ratio_e'(3'(k));
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/mrd_edge_sync.sv
module mrd_edge_sync #(
    parameter int N_SIG  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SIG-1:0] raw_in,
    output logic [N_SIG-1:0] rise_out
);

    for (genvar g = 0; g < N_SIG; g++) begin : g_bit
        logic [STAGES:0] shift_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                shift_q <= '0;
            end else begin
                shift_q <= {shift_q[STAGES-1:0], raw_in[g]};
            end
        end

        assign rise_out[g] = shift_q[STAGES-1] & ~shift_q[STAGES];
    end

endmodule

// File: rtl/mrd_clk_watchdog.sv
module mrd_clk_watchdog #(
    parameter int WIN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mclk_rise,
    input  logic [WIN_W-1:0] window,
    output logic             lost
);

    localparam logic [WIN_W-1:0] SAT = '1;

    logic [WIN_W-1:0] idle_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idle_q <= '0;
        end else if (mclk_rise) begin
            idle_q <= '0;
        end else if (idle_q != SAT) begin
            idle_q <= idle_q + 1'b1;
        end
    end

    assign lost = (idle_q >= window);

    // R9: a fresh master-clock edge always clears a pending loss
    a_r9_edge_clears_loss: assert property (@(posedge clk) disable iff (!rst_n)
        (mclk_rise && window != '0) |=> !lost);

endmodule

// File: rtl/mrd_period_counter.sv
module mrd_period_counter #(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             mclk_rise,
    input  logic             ws_rise,
    output logic             meas_valid,
    output logic             meas_over,
    output logic [CNT_W-1:0] meas_count
);

    localparam logic [CNT_W-1:0] CNT_FULL = '1;

    logic             armed_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            armed_q    <= 1'b0;
            cnt_q      <= '0;
            meas_valid <= 1'b0;
            meas_over  <= 1'b0;
            meas_count <= '0;
        end else begin
            meas_valid <= 1'b0;
            if (ws_rise) begin
                if (armed_q) begin
                    meas_valid <= 1'b1;
                    meas_over  <= 1'b0;
                    meas_count <= cnt_q;
                end
                armed_q <= 1'b1;
                cnt_q   <= mclk_rise ? CNT_W'(1) : '0;
            end else if (mclk_rise && armed_q) begin
                if (cnt_q == CNT_FULL) begin
                    meas_valid <= 1'b1;
                    meas_over  <= 1'b1;
                    meas_count <= cnt_q;
                    armed_q    <= 1'b0;
                    cnt_q      <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    // R10: an overrange result disarms, so it cannot repeat on the next cycle
    a_r10_over_single: assert property (@(posedge clk) disable iff (!rst_n)
        (meas_valid && meas_over) |=> !meas_valid);

endmodule

// File: rtl/mrd_lock_fsm.sv
module mrd_lock_fsm
    import mrd_pkg::*;
#(
    parameter int CNT_W = 11,
    parameter int TOL   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lost,
    input  logic             meas_valid,
    input  logic             meas_over,
    input  logic [CNT_W-1:0] meas_count,
    output logic             locked,
    output ratio_e           ratio_out
);

    typedef enum logic [1:0] {
        ST_HUNT    = 2'd0,
        ST_CONFIRM = 2'd1,
        ST_LOCKED  = 2'd2,
        ST_LOST    = 2'd3
    } state_e;

    state_e state_q, state_d;
    ratio_e cand_q;
    ratio_e meas_code;

    assign meas_code = meas_over ? RC_NONE
                                 : classify(32'(meas_count), 32'(TOL));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HUNT: begin
                if (lost)                                      state_d = ST_LOST;
                else if (meas_valid && meas_code != RC_NONE)   state_d = ST_CONFIRM;
            end
            ST_CONFIRM: begin
                if (lost)                                      state_d = ST_LOST;
                else if (meas_valid && meas_code == RC_NONE)   state_d = ST_HUNT;
                else if (meas_valid && meas_code == cand_q)    state_d = ST_LOCKED;
            end
            ST_LOCKED: begin
                if (lost)                                      state_d = ST_LOST;
                else if (meas_valid && meas_code == RC_NONE)   state_d = ST_HUNT;
                else if (meas_valid && meas_code != cand_q)    state_d = ST_CONFIRM;
            end
            ST_LOST: begin
                if (!lost)                                     state_d = ST_HUNT;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_HUNT;
            cand_q  <= RC_NONE;
        end else begin
            state_q <= state_d;
            if (lost) begin
                cand_q <= RC_NONE;
            end else if (meas_valid && meas_code != RC_NONE) begin
                cand_q <= meas_code;
            end
        end
    end

    always_comb begin
        unique case (state_q)
            ST_LOCKED: begin
                locked    = 1'b1;
                ratio_out = cand_q;
            end
            ST_HUNT, ST_CONFIRM, ST_LOST: begin
                locked    = 1'b0;
                ratio_out = RC_NONE;
            end
        endcase
    end

    // R5: lock only rises as the result of a measurement
    a_r5_lock_follows_meas: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(meas_valid));

    // R9: a watchdog loss removes lock on the next cycle
    a_r9_loss_drops_lock: assert property (@(posedge clk) disable iff (!rst_n)
        lost |=> !locked);

    // R7: the reported ratio cannot change while lock is held
    a_r7_code_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && $past(locked)) |-> $stable(ratio_out));

endmodule

// File: rtl/mrd_rate_divider.sv
module mrd_rate_divider (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       locked,
    input  logic       ws_rise,
    input  logic       mclk_rise,
    input  logic [3:0] step,
    output logic       div_en
);

    logic [3:0] phase_q;

    always_ff @(posedge clk) begin
        if (!rst_n || !locked) begin
            phase_q <= '0;
            div_en  <= 1'b0;
        end else begin
            div_en <= 1'b0;
            if (ws_rise) begin
                phase_q <= mclk_rise ? 4'd1 : 4'd0;
            end else if (mclk_rise) begin
                if (phase_q == step - 4'd1) begin
                    phase_q <= '0;
                    div_en  <= 1'b1;
                end else begin
                    phase_q <= phase_q + 4'd1;
                end
            end
        end
    end

    // R8: a divide pulse is only issued when lock was held the cycle before
    a_r8_pulse_needs_lock: assert property (@(posedge clk) disable iff (!rst_n)
        div_en |-> $past(locked));

endmodule

// File: rtl/mrd_ratio_detector.sv
module mrd_ratio_detector
    import mrd_pkg::*;
#(
    parameter int CNT_W       = 11,
    parameter int WIN_W       = 16,
    parameter int TOL         = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk_ref,
    input  logic             rst_n,
    input  logic             mclk,
    input  logic             frame_clk,
    input  logic [WIN_W-1:0] loss_window,
    output logic             locked,
    output logic             reset_req,
    output logic [1:0]       speed_mode,
    output logic [2:0]       ratio_code,
    output logic [7:0]       osr_factor,
    output logic             div_en
);

    localparam int IDX_MCLK = 0;
    localparam int IDX_WS   = 1;

    logic [1:0]       rises;
    logic             mclk_rise;
    logic             ws_rise;
    logic             lost;
    logic             meas_valid;
    logic             meas_over;
    logic [CNT_W-1:0] meas_count;
    logic             lock_int;
    ratio_e           code;
    speed_e           speed;

    mrd_edge_sync #(.N_SIG(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk_ref),
        .rst_n    (rst_n),
        .raw_in   ({frame_clk, mclk}),
        .rise_out (rises)
    );

    assign mclk_rise = rises[IDX_MCLK];
    assign ws_rise   = rises[IDX_WS];

    mrd_clk_watchdog #(.WIN_W(WIN_W)) u_wdog (
        .clk       (clk_ref),
        .rst_n     (rst_n),
        .mclk_rise (mclk_rise),
        .window    (loss_window),
        .lost      (lost)
    );

    mrd_period_counter #(.CNT_W(CNT_W)) u_count (
        .clk        (clk_ref),
        .rst_n      (rst_n),
        .flush      (lost),
        .mclk_rise  (mclk_rise),
        .ws_rise    (ws_rise),
        .meas_valid (meas_valid),
        .meas_over  (meas_over),
        .meas_count (meas_count)
    );

    mrd_lock_fsm #(.CNT_W(CNT_W), .TOL(TOL)) u_fsm (
        .clk        (clk_ref),
        .rst_n      (rst_n),
        .lost       (lost),
        .meas_valid (meas_valid),
        .meas_over  (meas_over),
        .meas_count (meas_count),
        .locked     (lock_int),
        .ratio_out  (code)
    );

    mrd_rate_divider u_div (
        .clk       (clk_ref),
        .rst_n     (rst_n),
        .locked    (lock_int),
        .ws_rise   (ws_rise),
        .mclk_rise (mclk_rise),
        .step      (step_of(code)),
        .div_en    (div_en)
    );

    assign speed      = speed_of(code);
    assign speed_mode = speed;
    assign ratio_code = code;
    assign osr_factor = osr_of(speed);
    assign locked     = lock_int;
    assign reset_req  = ~lock_int;

endmodule

// File: tb/mrd_ratio_detector_tb.sv
module mrd_ratio_detector_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WINDOW     = 64;
    localparam int MAX_CYCLES = 180000;

    logic        clk_ref = 1'b0;
    logic        rst_n   = 1'b0;
    logic        mclk    = 1'b0;
    logic        frame_clk = 1'b0;
    logic [15:0] loss_window = 16'(WINDOW);
    logic        locked;
    logic        reset_req;
    logic [1:0]  speed_mode;
    logic [2:0]  ratio_code;
    logic [7:0]  osr_factor;
    logic        div_en;

    int checks = 0;
    int fails  = 0;
    int div_total = 0;

    typedef struct {
        int    delay;
        bit    lock;
        int    mode;
        int    code;
        int    osr;
        string tag;
    } exp_t;

    exp_t exp_q[$];

    always #(CLK_PERIOD/2) clk_ref = ~clk_ref;

    mrd_ratio_detector u_dut (
        .clk_ref     (clk_ref),
        .rst_n       (rst_n),
        .mclk        (mclk),
        .frame_clk   (frame_clk),
        .loss_window (loss_window),
        .locked      (locked),
        .reset_req   (reset_req),
        .speed_mode  (speed_mode),
        .ratio_code  (ratio_code),
        .osr_factor  (osr_factor),
        .div_en      (div_en)
    );

    always @(negedge clk_ref) begin
        if (div_en === 1'b1) div_total <= div_total + 1;
    end

    // expected values straight from the requirement text
    function automatic int exp_code(int n);
        case (n)
            128: return 1;  192: return 2;  256: return 3;  384: return 4;
            512: return 5;  768: return 6;  1152: return 7;
            default: return 0;
        endcase
    endfunction

    function automatic int exp_mode(int code);
        if (code == 0) return 0;
        if (code <= 2) return 3;
        if (code <= 4) return 2;
        return 1;
    endfunction

    function automatic int exp_osr(int mode);
        case (mode)
            1: return 128;  2: return 64;  3: return 32;
            default: return 0;
        endcase
    endfunction

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    task automatic check_range(string tag, int act, int lo, int hi);
        checks++;
        if (act < lo || act > hi) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d..%0d", tag, act, lo, hi);
        end
    endtask

    task automatic expect_state(int delay, bit lk, int code, string tag);
        exp_t e;
        e.delay = delay;
        e.lock  = lk;
        e.code  = code;
        e.mode  = exp_mode(code);
        e.osr   = exp_osr(e.mode);
        e.tag   = tag;
        exp_q.push_back(e);
    endtask

    task automatic drain();
        wait (exp_q.size() == 0);
    endtask

    // monitor: pops expected items and compares the ports at a falling edge
    initial begin
        exp_t cur;
        forever begin
            wait (exp_q.size() != 0);
            cur = exp_q[0];
            repeat (cur.delay) @(negedge clk_ref);
            @(negedge clk_ref);
            checks++;
            if (locked !== cur.lock || reset_req !== !cur.lock ||
                int'(speed_mode) != cur.mode || int'(ratio_code) != cur.code ||
                int'(osr_factor) != cur.osr) begin
                fails++;
                $display("FAIL %s: actual lock=%0d req=%0d mode=%0d code=%0d osr=%0d expected lock=%0d req=%0d mode=%0d code=%0d osr=%0d",
                         cur.tag, locked, reset_req, speed_mode, ratio_code, osr_factor,
                         cur.lock, !cur.lock, cur.mode, cur.code, cur.osr);
            end
            void'(exp_q.pop_front());
        end
    end

    // one master-clock period = 4 reference cycles; frame clock moves with the fall
    task automatic mclk_cycle(bit ws_v);
        @(negedge clk_ref) mclk = 1'b1;
        @(negedge clk_ref);
        @(negedge clk_ref) begin
            mclk = 1'b0;
            frame_clk = ws_v;
        end
        @(negedge clk_ref);
    endtask

    task automatic run_frames(int n, int frames);
        for (int f = 0; f < frames; f++) begin
            for (int i = 0; i < n; i++) mclk_cycle(i < n/2);
        end
    endtask

    task automatic sweep(int n, string tag);
        int d0;
        int o;
        run_frames(n, 4);
        expect_state(0, 1'b1, exp_code(n), tag);
        drain();
        o = exp_osr(exp_mode(exp_code(n)));
        d0 = div_total;
        run_frames(n, 2);
        check_range({tag, " R8 div_en per 2 frames"}, div_total - d0, 2*o - 2, 2*o + 2);
    endtask

    initial begin
        repeat (MAX_CYCLES) @(posedge clk_ref);
        checks++;
        fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        int d0;
        int n;
        repeat (5) @(negedge clk_ref);
        rst_n = 1'b1;
        repeat (4) @(negedge clk_ref);
        // R6: reset state
        expect_state(0, 1'b0, 0, "R6 reset state");
        drain();

        sweep(512,  "R1 x512");
        sweep(768,  "R1 x768");
        sweep(1152, "R1 x1152");
        sweep(256,  "R2 x256");
        sweep(384,  "R2 x384");
        sweep(128,  "R3 x128");
        sweep(192,  "R3 x192");

        // R4: tolerance edges
        run_frames(130, 4);
        expect_state(0, 1'b1, 1, "R4 130 accepted");
        drain();
        run_frames(125, 4);
        expect_state(0, 1'b0, 0, "R4 125 rejected");
        drain();

        // R11: unsupported ratio, no divide pulses
        run_frames(640, 4);
        expect_state(0, 1'b0, 0, "R11 640 rejected");
        drain();
        d0 = div_total;
        run_frames(640, 2);
        check_range("R11 R8 div_en while unlocked", div_total - d0, 0, 0);

        // R5: two matching measurements needed
        run_frames(256, 2);
        expect_state(0, 1'b0, 0, "R5 one measurement only");
        drain();
        run_frames(256, 1);
        expect_state(0, 1'b1, 3, "R5 locked after second");
        drain();

        // R7: ratio change while locked, checked around the breaking frame edge
        expect_state(4*384 - 16, 1'b1, 3, "R7 before breaking measurement");
        expect_state(40, 1'b0, 0, "R7 after breaking measurement");
        run_frames(384, 3);
        drain();
        expect_state(0, 1'b1, 4, "R7 relocked on new ratio");
        drain();

        // R9: master clock stops
        n = 0;
        while (reset_req !== 1'b1 && n < 200) begin
            @(negedge clk_ref);
            n++;
        end
        check_range("R9 loss detection latency", n, WINDOW - 6, WINDOW + 6);
        expect_state(0, 1'b0, 0, "R9 state after loss");
        drain();
        run_frames(192, 4);
        expect_state(0, 1'b1, 2, "R9 relock after restart");
        drain();

        // R10: frame clock stops, master clock keeps running
        for (int i = 0; i < 1800; i++) mclk_cycle(1'b0);
        expect_state(0, 1'b1, 2, "R10 held below overrange");
        drain();
        for (int i = 0; i < 100; i++) mclk_cycle(1'b0);
        expect_state(0, 1'b0, 0, "R10 overrange clears lock");
        drain();

        finish_run();
    end

endmodule